// File: doc/BRIEF.md
# Reservation Station with Scoreboard Wakeup

This block is an issue queue for an out-of-order core. It holds decoded instructions in program order until their operands can be read. A register availability vector keeps one ready bit per architectural register. When an instruction is dispatched, each of its sources is looked up in that vector. The bit of its target is then cleared, so that later readers wait for the new value.

When an instruction's execution latency runs out, the station broadcasts the target register as a bit mask. Waiting entries capture that readiness, and the vector bit is set again. One ready entry is issued per cycle, and the entry closest to the queue head goes first. Each slot carries a visible status that moves through free, waiting, ready, executing, completed and committed.

Commit follows program order even when younger work finishes first. Committed slots are released from the head. Operand values, renaming and the reorder buffer sit outside this block.

Slot status codes are FREE=0, WAIT=1, RDY=2, EXEC=3, COMPL=4 and CMTD=5. The slot FSM uses these transitions:

- FREE to WAIT or RDY on dispatch.
- WAIT to RDY on wakeup.
- RDY to EXEC on issue.
- EXEC to COMPL when the latency expires.
- COMPL to CMTD on commit.
- CMTD to FREE on release.

Top module: `rs_wakeup_station`

## Requirements
- R1: After reset every slot is FREE (code 0), every availability bit is 1, and `issue_valid`, `wake_mask` and `commit_valid` are all zero.
- R2: A dispatch is taken when `disp_valid` and `disp_ready` are both high. It fills the tail slot, and slots are handed out in circular order starting at slot 0 after reset. The new slot is RDY (2) when every used source is ready, and WAIT (1) otherwise. An unused source counts as ready.
- R3: Taking a dispatch that has a target clears that register's availability bit from the next cycle on. A broadcast of a register sets its bit from the next cycle on.
- R4: `disp_ready` is low when all DEPTH slots are occupied. It is also low when the offered instruction has a target whose availability bit is clear.
- R5: If a source register is broadcast in the same cycle that its reader is dispatched, the source is captured as ready.
- R6: A WAIT slot whose last missing source is broadcast becomes RDY in the next cycle and can issue in that cycle.
- R7: At most one slot issues per cycle, and it is the RDY slot nearest the head. The `issue_*` outputs describe that slot, and the slot is EXEC from the next cycle.
- R8: An instruction with opcode 1 (a load) broadcasts its target in the fourth cycle after its issue cycle. Any other opcode broadcasts in the cycle after issue. The broadcast cycle is the slot's last EXEC cycle, and the slot is COMPL next. Only registers with a clear availability bit are ever broadcast.
- R9: `commit_valid` is high, with `commit_slot` equal to the head, only while the head slot is COMPL. That slot is CMTD in the next cycle. Younger COMPL slots wait for the head.
- R10: A CMTD slot at the head is FREE in the next cycle and the head advances. `commit_valid` stays low while the head is CMTD.
- R11: A slot never issues while an older in-flight slot still owes one of its source registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch offer |
| disp_op | input | OPW | Opcode of offered instruction |
| disp_src0_use | input | 1 | Source 0 is a register |
| disp_src0 | input | RW | Source 0 register |
| disp_src1_use | input | 1 | Source 1 is a register |
| disp_src1 | input | RW | Source 1 register |
| disp_dst_use | input | 1 | Instruction writes a register |
| disp_dst | input | RW | Target register |
| disp_ready | output | 1 | Offer can be taken this cycle |
| issue_valid | output | 1 | A slot issues this cycle |
| issue_slot | output | IW | Index of issuing slot |
| issue_op | output | OPW | Opcode of issuing slot |
| issue_dst_use | output | 1 | Issuing slot writes a register |
| issue_dst | output | RW | Target of issuing slot |
| wake_mask | output | NREGS | Registers produced this cycle |
| commit_valid | output | 1 | Head slot commits this cycle |
| commit_slot | output | IW | Index of committing slot |
| reg_avail | output | NREGS | Availability vector |
| slot_state | output | 3*DEPTH | Status code of each slot, slot i at bits 3i+2..3i |

## Verification
The bench builds the station with four slots, eight registers and a load latency of four. With four slots the queue fills often under random traffic, so the full stall and the wrap of the head and tail pointers occur many times. Eight registers make target collisions and shared sources common, which keeps the target-pending stall and multi-waiter wakeups busy. A four-cycle load lets a younger one-cycle instruction complete while an older load is still running, which exercises the in-order commit path.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [2:0] {
        ST_FREE  = 3'd0,
        ST_WAIT  = 3'd1,
        ST_RDY   = 3'd2,
        ST_EXEC  = 3'd3,
        ST_COMPL = 3'd4,
        ST_CMTD  = 3'd5
    } slot_state_e;

endpackage

// File: rtl/rs_avail_vec.sv
module rs_avail_vec #(
    parameter int NREGS = 32,
    localparam int RW = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NREGS-1:0] set_mask,
    input  logic             clr_en,
    input  logic [RW-1:0]    clr_reg,
    output logic [NREGS-1:0] avail
);

    logic [NREGS-1:0] clr_mask;

    always_comb begin
        clr_mask = '0;
        if (clr_en) clr_mask[clr_reg] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) avail <= '1;
        else        avail <= (avail | set_mask) & ~clr_mask;
    end

endmodule

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pkg::*;
#(
    parameter int NREGS    = 32,
    parameter int OPW      = 4,
    parameter int LOAD_LAT = 4,
    parameter int LOAD_OP  = 1,
    localparam int RW = $clog2(NREGS),
    localparam int LW = $clog2(LOAD_LAT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic [OPW-1:0]   a_op,
    input  logic [RW-1:0]    a_src0,
    input  logic             a_src0_rdy,
    input  logic [RW-1:0]    a_src1,
    input  logic             a_src1_rdy,
    input  logic             a_dst_use,
    input  logic [RW-1:0]    a_dst,
    input  logic             grant,
    input  logic [NREGS-1:0] wake,
    input  logic             retire,
    input  logic             release_slot,
    output slot_state_e      state_o,
    output logic [OPW-1:0]   op_o,
    output logic             dst_use_o,
    output logic [RW-1:0]    dst_o,
    output logic             done_o
);

    slot_state_e    state_q, state_d;
    logic [RW-1:0]  src0_q, src1_q;
    logic           rdy0_q, rdy1_q;
    logic [LW-1:0]  timer_q;
    logic           rdy0_now, rdy1_now;

    assign rdy0_now = rdy0_q | wake[src0_q];
    assign rdy1_now = rdy1_q | wake[src1_q];

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FREE:  if (alloc) state_d = (a_src0_rdy && a_src1_rdy) ? ST_RDY : ST_WAIT;
            ST_WAIT:  if (rdy0_now && rdy1_now) state_d = ST_RDY;
            ST_RDY:   if (grant) state_d = ST_EXEC;
            ST_EXEC:  if (timer_q == LW'(1)) state_d = ST_COMPL;
            ST_COMPL: if (retire) state_d = ST_CMTD;
            ST_CMTD:  if (release_slot) state_d = ST_FREE;
            default:  state_d = ST_FREE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FREE;
        else        state_q <= state_d;
    end

    // payload and operand tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_o      <= '0;
            src0_q    <= '0;
            src1_q    <= '0;
            rdy0_q    <= 1'b1;
            rdy1_q    <= 1'b1;
            dst_use_o <= 1'b0;
            dst_o     <= '0;
            timer_q   <= '0;
        end else begin
            if (state_q == ST_FREE && alloc) begin
                op_o      <= a_op;
                src0_q    <= a_src0;
                src1_q    <= a_src1;
                rdy0_q    <= a_src0_rdy;
                rdy1_q    <= a_src1_rdy;
                dst_use_o <= a_dst_use;
                dst_o     <= a_dst;
            end else if (state_q == ST_WAIT) begin
                rdy0_q <= rdy0_now;
                rdy1_q <= rdy1_now;
            end
            if (state_q == ST_RDY && grant)
                timer_q <= (op_o == OPW'(LOAD_OP)) ? LW'(LOAD_LAT) : LW'(1);
            else if (state_q == ST_EXEC)
                timer_q <= timer_q - LW'(1);
        end
    end

    // outputs
    always_comb begin
        state_o = state_q;
        done_o  = (state_q == ST_EXEC) && (timer_q == LW'(1));
    end

endmodule

// File: rtl/rs_oldest_pick.sv
module rs_oldest_pick #(
    parameter int DEPTH = 8,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] cand,
    input  logic [IW-1:0]    head,
    output logic             found,
    output logic [IW-1:0]    idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            logic [IW-1:0] pos;
            pos = head + IW'(k);
            if (cand[pos]) begin
                found = 1'b1;
                idx   = pos;
            end
        end
    end

endmodule

// File: rtl/rs_wakeup_station.sv
module rs_wakeup_station
    import rs_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int NREGS    = 32,
    parameter int OPW      = 4,
    parameter int LOAD_LAT = 4,
    parameter int LOAD_OP  = 1,
    localparam int RW = $clog2(NREGS),
    localparam int IW = $clog2(DEPTH),
    localparam int CW = IW + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               disp_valid,
    input  logic [OPW-1:0]     disp_op,
    input  logic               disp_src0_use,
    input  logic [RW-1:0]      disp_src0,
    input  logic               disp_src1_use,
    input  logic [RW-1:0]      disp_src1,
    input  logic               disp_dst_use,
    input  logic [RW-1:0]      disp_dst,
    output logic               disp_ready,
    output logic               issue_valid,
    output logic [IW-1:0]      issue_slot,
    output logic [OPW-1:0]     issue_op,
    output logic               issue_dst_use,
    output logic [RW-1:0]      issue_dst,
    output logic [NREGS-1:0]   wake_mask,
    output logic               commit_valid,
    output logic [IW-1:0]      commit_slot,
    output logic [NREGS-1:0]   reg_avail,
    output logic [3*DEPTH-1:0] slot_state
);

    logic [IW-1:0] head_q, tail_q;
    logic [CW-1:0] count_q;
    logic          accept, head_free;
    logic          src0_rdy, src1_rdy;

    slot_state_e    st_arr  [DEPTH];
    logic [OPW-1:0] op_arr  [DEPTH];
    logic           du_arr  [DEPTH];
    logic [RW-1:0]  dst_arr [DEPTH];
    logic [DEPTH-1:0] done_vec, rdy_vec, alloc_vec, grant_vec, retire_vec, release_vec;

    // dispatch admission and operand lookup with same-cycle bypass
    assign disp_ready = (count_q != CW'(DEPTH)) && (!disp_dst_use || reg_avail[disp_dst]);
    assign accept     = disp_valid && disp_ready;
    assign src0_rdy   = !disp_src0_use || reg_avail[disp_src0] || wake_mask[disp_src0];
    assign src1_rdy   = !disp_src1_use || reg_avail[disp_src1] || wake_mask[disp_src1];

    rs_avail_vec #(.NREGS(NREGS)) u_avail (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (wake_mask),
        .clr_en   (accept && disp_dst_use),
        .clr_reg  (disp_dst),
        .avail    (reg_avail)
    );

    rs_oldest_pick #(.DEPTH(DEPTH)) u_pick (
        .cand  (rdy_vec),
        .head  (head_q),
        .found (issue_valid),
        .idx   (issue_slot)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        assign alloc_vec[i]   = accept && (tail_q == IW'(i));
        assign grant_vec[i]   = issue_valid && (issue_slot == IW'(i));
        assign retire_vec[i]  = (head_q == IW'(i)) && (st_arr[i] == ST_COMPL);
        assign release_vec[i] = (head_q == IW'(i)) && (st_arr[i] == ST_CMTD);
        assign rdy_vec[i]     = (st_arr[i] == ST_RDY);
        assign slot_state[3*i +: 3] = st_arr[i];

        rs_slot #(
            .NREGS(NREGS), .OPW(OPW), .LOAD_LAT(LOAD_LAT), .LOAD_OP(LOAD_OP)
        ) u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .alloc        (alloc_vec[i]),
            .a_op         (disp_op),
            .a_src0       (disp_src0),
            .a_src0_rdy   (src0_rdy),
            .a_src1       (disp_src1),
            .a_src1_rdy   (src1_rdy),
            .a_dst_use    (disp_dst_use),
            .a_dst        (disp_dst),
            .grant        (grant_vec[i]),
            .wake         (wake_mask),
            .retire       (retire_vec[i]),
            .release_slot (release_vec[i]),
            .state_o      (st_arr[i]),
            .op_o         (op_arr[i]),
            .dst_use_o    (du_arr[i]),
            .dst_o        (dst_arr[i]),
            .done_o       (done_vec[i])
        );
    end

    // result broadcast
    always_comb begin
        wake_mask = '0;
        for (int i = 0; i < DEPTH; i++)
            if (done_vec[i] && du_arr[i]) wake_mask[dst_arr[i]] = 1'b1;
    end

    // issue and commit outputs
    assign issue_op      = op_arr[issue_slot];
    assign issue_dst_use = du_arr[issue_slot];
    assign issue_dst     = dst_arr[issue_slot];
    assign commit_valid  = (st_arr[head_q] == ST_COMPL);
    assign commit_slot   = head_q;
    assign head_free     = (st_arr[head_q] == ST_CMTD);

    // queue pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (accept)    tail_q <= tail_q + IW'(1);
            if (head_free) head_q <= head_q + IW'(1);
            count_q <= count_q + CW'(accept) - CW'(head_free);
        end
    end

endmodule

// File: rtl/rs_wakeup_station_chk.sv
module rs_wakeup_station_chk #(
    parameter int DEPTH = 8,
    parameter int NREGS = 32,
    localparam int RW = $clog2(NREGS),
    localparam int IW = $clog2(DEPTH)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               disp_valid,
    input logic               disp_dst_use,
    input logic [RW-1:0]      disp_dst,
    input logic               disp_ready,
    input logic               issue_valid,
    input logic [IW-1:0]      issue_slot,
    input logic [NREGS-1:0]   wake_mask,
    input logic               commit_valid,
    input logic [IW-1:0]      commit_slot,
    input logic [NREGS-1:0]   reg_avail,
    input logic [3*DEPTH-1:0] slot_state
);

    logic [IW-1:0] last_issue, last_commit;
    logic [RW-1:0] last_dst;

    always_ff @(posedge clk) begin
        last_issue  <= issue_slot;
        last_commit <= commit_slot;
        last_dst    <= disp_dst;
    end

    // issued slot is executing one cycle later (R7)
    assert_issue_exec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> slot_state[3*last_issue +: 3] == 3'd3);

    // committing head slot is committed one cycle later (R9)
    assert_commit_cmtd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |=> slot_state[3*last_commit +: 3] == 3'd5);

    // accepted target clears its availability bit (R3)
    assert_dst_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_ready && disp_dst_use) |=> !reg_avail[last_dst]);

    // broadcast registers become available (R3)
    assert_wake_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|wake_mask) |=> ((reg_avail & $past(wake_mask)) == $past(wake_mask)));

    // pending target blocks dispatch (R4)
    assert_pending_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_dst_use && !reg_avail[disp_dst]) |-> !disp_ready);

    // only pending registers are broadcast (R8)
    assert_wake_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_mask & reg_avail) == '0);

endmodule

bind rs_wakeup_station rs_wakeup_station_chk #(.DEPTH(DEPTH), .NREGS(NREGS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .disp_valid   (disp_valid),
    .disp_dst_use (disp_dst_use),
    .disp_dst     (disp_dst),
    .disp_ready   (disp_ready),
    .issue_valid  (issue_valid),
    .issue_slot   (issue_slot),
    .wake_mask    (wake_mask),
    .commit_valid (commit_valid),
    .commit_slot  (commit_slot),
    .reg_avail    (reg_avail),
    .slot_state   (slot_state)
);

// File: tb/rs_wakeup_station_tb.sv
module rs_wakeup_station_tb;

    localparam int DEPTH = 4, NREGS = 8, OPW = 4, LOAD_LAT = 4, LOAD_OP = 1;
    localparam int RW = 3, IW = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic               rst_n;
    logic               disp_valid, disp_src0_use, disp_src1_use, disp_dst_use;
    logic [OPW-1:0]     disp_op;
    logic [RW-1:0]      disp_src0, disp_src1, disp_dst;
    logic               disp_ready, issue_valid, issue_dst_use, commit_valid;
    logic [IW-1:0]      issue_slot, commit_slot;
    logic [OPW-1:0]     issue_op;
    logic [RW-1:0]      issue_dst;
    logic [NREGS-1:0]   wake_mask, reg_avail;
    logic [3*DEPTH-1:0] slot_state;

    rs_wakeup_station #(
        .DEPTH(DEPTH), .NREGS(NREGS), .OPW(OPW), .LOAD_LAT(LOAD_LAT), .LOAD_OP(LOAD_OP)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_op(disp_op),
        .disp_src0_use(disp_src0_use), .disp_src0(disp_src0),
        .disp_src1_use(disp_src1_use), .disp_src1(disp_src1),
        .disp_dst_use(disp_dst_use), .disp_dst(disp_dst), .disp_ready(disp_ready),
        .issue_valid(issue_valid), .issue_slot(issue_slot), .issue_op(issue_op),
        .issue_dst_use(issue_dst_use), .issue_dst(issue_dst),
        .wake_mask(wake_mask), .commit_valid(commit_valid), .commit_slot(commit_slot),
        .reg_avail(reg_avail), .slot_state(slot_state)
    );

    int  total = 0, bad = 0, cyc = 0;
    bit  mon_on = 1'b0, finished = 1'b0;

    // bench model of program order, pending registers and in-flight latency
    logic [OPW-1:0] m_op [DEPTH];
    bit             m_s0u [DEPTH], m_s1u [DEPTH], m_du [DEPTH], m_fly [DEPTH];
    int             m_s0 [DEPTH], m_s1 [DEPTH], m_dst [DEPTH], m_done [DEPTH];
    bit             pend [NREGS];
    int             prod [NREGS];
    int             tb_tail = 0;
    int             ord_q [$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int st(input int s);
        return int'(slot_state[3*s +: 3]);
    endfunction

    function automatic int lat_of(input logic [OPW-1:0] op);
        return (op == OPW'(LOAD_OP)) ? LOAD_LAT : 1;
    endfunction

    function automatic logic [NREGS-1:0] model_avail();
        logic [NREGS-1:0] v;
        for (int r = 0; r < NREGS; r++) v[r] = !pend[r];
        return v;
    endfunction

    // monitor: samples at the falling edge
    always @(negedge clk) begin
        if (mon_on) begin
            cyc++;
            check(reg_avail == model_avail(), "R3", "availability vector",
                  int'(reg_avail), int'(model_avail()));
            if (issue_valid) begin
                int s;
                s = int'(issue_slot);
                check(issue_op == m_op[s], "R7", "issued opcode", int'(issue_op), int'(m_op[s]));
                if (m_s0u[s])
                    check(!(pend[m_s0[s]] && prod[m_s0[s]] != s), "R11", "src0 still owed", 1, 0);
                if (m_s1u[s])
                    check(!(pend[m_s1[s]] && prod[m_s1[s]] != s), "R11", "src1 still owed", 1, 0);
                m_fly[s]  = 1'b1;
                m_done[s] = cyc + lat_of(m_op[s]);
            end
            for (int s = 0; s < DEPTH; s++) begin
                if (m_fly[s] && m_done[s] == cyc) begin
                    if (m_du[s])
                        check(wake_mask[m_dst[s]], "R8", "broadcast at latency end", 0, 1);
                    m_fly[s] = 1'b0;
                end
            end
            for (int r = 0; r < NREGS; r++)
                if (wake_mask[r]) check(pend[r], "R8", "broadcast of non-pending reg", r, -1);
            if (commit_valid) begin
                int exp_s;
                exp_s = (ord_q.size() > 0) ? ord_q[0] : -1;
                check(int'(commit_slot) == exp_s, "R9", "commit order", int'(commit_slot), exp_s);
                if (ord_q.size() > 0) void'(ord_q.pop_front());
            end
            for (int r = 0; r < NREGS; r++)
                if (wake_mask[r]) pend[r] = 1'b0;
            if (disp_valid && disp_ready) begin
                m_op[tb_tail]  = disp_op;
                m_s0u[tb_tail] = disp_src0_use;
                m_s0[tb_tail]  = int'(disp_src0);
                m_s1u[tb_tail] = disp_src1_use;
                m_s1[tb_tail]  = int'(disp_src1);
                m_du[tb_tail]  = disp_dst_use;
                m_dst[tb_tail] = int'(disp_dst);
                m_fly[tb_tail] = 1'b0;
                if (disp_dst_use) begin
                    pend[disp_dst] = 1'b1;
                    prod[disp_dst] = tb_tail;
                end
                ord_q.push_back(tb_tail);
                tb_tail = (tb_tail + 1) % DEPTH;
            end
        end
    end

    task automatic nxt();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        #2;
    endtask

    task automatic drive(input bit v, input int op, input bit u0, input int r0,
                         input bit u1, input int r1, input bit ud, input int rd);
        disp_valid    = v;
        disp_op       = OPW'(op);
        disp_src0_use = u0;
        disp_src0     = RW'(r0);
        disp_src1_use = u1;
        disp_src1     = RW'(r1);
        disp_dst_use  = ud;
        disp_dst      = RW'(rd);
    endtask

    task automatic idle();
        drive(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic drain(input int limit, input string req);
        idle();
        for (int i = 0; i < limit; i++) begin
            nxt();
            settle();
            if (slot_state == '0) break;
        end
        check(slot_state == '0, req, "queue drained", int'(slot_state), 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: run did not end: actual=hung expected=done");
        finish_run();
    end

    initial begin
        int s0, s1, s2, s3, sl, sx;
        void'($urandom(32'h1f3c_5a77));
        rst_n = 1'b0;
        idle();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        mon_on = 1'b1;
        settle();
        // R1 reset state
        check(slot_state == '0, "R1", "slots free", int'(slot_state), 0);
        check(reg_avail == '1, "R1", "vector all ones", int'(reg_avail), 255);
        check(!issue_valid && wake_mask == '0 && !commit_valid, "R1", "quiet outputs", 1, 0);

        // scenario: load producer, two waiters, bypass, stalls
        nxt(); s0 = tb_tail; drive(1, 1, 0, 0, 0, 0, 1, 2); settle();
        nxt(); s1 = tb_tail; drive(1, 2, 1, 2, 0, 0, 1, 3); settle();
        check(st(s0) == 2, "R2", "no-source slot RDY", st(s0), 2);
        check(issue_valid && int'(issue_slot) == s0, "R7", "first issue", int'(issue_slot), s0);
        nxt(); s2 = tb_tail; drive(1, 2, 1, 2, 0, 0, 1, 5); settle();
        check(st(s1) == 1, "R2", "waiting slot WAIT", st(s1), 1);
        check(st(s0) == 3, "R7", "issued slot EXEC", st(s0), 3);
        nxt(); drive(1, 2, 0, 0, 0, 0, 1, 2); settle();
        check(!disp_ready, "R4", "pending target stalls", int'(disp_ready), 0);
        nxt(); idle(); settle();
        nxt(); s3 = tb_tail; drive(1, 2, 1, 2, 0, 0, 1, 1); settle();
        check(wake_mask[2], "R8", "load broadcast 4 cycles after issue", int'(wake_mask), 4);
        check(disp_ready, "R5", "dispatch taken in broadcast cycle", int'(disp_ready), 1);
        nxt(); drive(1, 2, 0, 0, 0, 0, 1, 0); settle();
        check(!disp_ready, "R4", "full stall", int'(disp_ready), 0);
        check(st(s1) == 2, "R6", "waiter woken", st(s1), 2);
        check(st(s3) == 2, "R5", "bypass source ready", st(s3), 2);
        check(issue_valid && int'(issue_slot) == s1, "R7", "oldest ready first", int'(issue_slot), s1);
        check(st(s0) == 4, "R8", "load COMPL", st(s0), 4);
        check(commit_valid && int'(commit_slot) == s0, "R9", "head commits", int'(commit_slot), s0);
        nxt(); idle(); settle();
        check(int'(issue_slot) == s2, "R7", "next oldest", int'(issue_slot), s2);
        check(st(s0) == 5, "R9", "head CMTD", st(s0), 5);
        check(!commit_valid, "R10", "no commit while head CMTD", int'(commit_valid), 0);
        nxt(); settle();
        check(int'(issue_slot) == s3, "R7", "youngest last", int'(issue_slot), s3);
        check(st(s0) == 0, "R10", "head released", st(s0), 0);
        drain(100, "R10");

        // scenario: younger finishes first, commit stays in order
        nxt(); sl = tb_tail; drive(1, 1, 0, 0, 0, 0, 1, 6); settle();
        nxt(); sx = tb_tail; drive(1, 3, 0, 0, 0, 0, 1, 7); settle();
        check(int'(issue_slot) == sl, "R7", "load issues", int'(issue_slot), sl);
        nxt(); idle(); settle();
        check(int'(issue_slot) == sx, "R7", "alu issues", int'(issue_slot), sx);
        nxt(); settle();
        nxt(); settle();
        nxt(); settle();
        check(st(sx) == 4, "R9", "younger COMPL", st(sx), 4);
        check(!commit_valid, "R9", "younger waits for head", int'(commit_valid), 0);
        check(st(sl) == 3, "R8", "load still EXEC", st(sl), 3);
        nxt(); settle();
        check(commit_valid && int'(commit_slot) == sl, "R9", "load commits first", int'(commit_slot), sl);
        nxt(); settle();
        check(!commit_valid, "R10", "gap while head CMTD", int'(commit_valid), 0);
        nxt(); settle();
        check(commit_valid && int'(commit_slot) == sx, "R9", "younger commits", int'(commit_slot), sx);
        drain(100, "R10");

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            nxt();
            drive(($urandom % 4) != 0, int'($urandom % 4),
                  ($urandom % 3) != 0, int'($urandom % NREGS),
                  ($urandom % 2) != 0, int'($urandom % NREGS),
                  ($urandom % 4) != 0, int'($urandom % NREGS));
        end
        drain(300, "R11");
        check(reg_avail == '1, "R3", "all registers available after drain", int'(reg_avail), 255);
        check(ord_q.size() == 0, "R9", "every dispatch committed", ord_q.size(), 0);
        finish_run();
    end

endmodule